// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Tag Controller

This block owns the tag side of a direct-mapped instruction cache. It drives an external synchronous tag RAM through a strobe, a read/write line, an index, a write-data bus and a read-data bus. It turns three commands into tag RAM cycles. A fetch lookup reads one entry and reports hit or miss. A line fill writes one entry with its valid flag set. An invalidate-all clears every entry. The data array, refill sequencing and system bus are handled elsewhere.

The cache size is a parameter, a power of two from 512 bytes to 32 KB. It fixes the boundary bit K = log2(size). Address bits 31..K form the tag, and bits K-1 down to the line offset width form the index. The tag word occupies bus bits 31..8. Bit 8 is always the valid flag. Bits 31..K hold the tag, and any bits in between are unused. Each access takes two clocks: one with the strobe high and one with it low. Only one command is accepted at a time, and only while the block is idle.

Top module: `icache_tag_ctrl`

## Requirements
- R1: During and right after reset, `busy`, `hit_valid`, `hit` and `tag_strobe` are 0.
- R2: A fetch accepted while idle raises `tag_strobe` for exactly one cycle with `tag_rw`=1 (read) and `tag_index` = address bits K-1..log2(LINE_BYTES). In the following cycle `hit_valid` pulses for one cycle and `busy` falls.
- R3: `hit` is 1 only when the returned word has bit 8 (valid) set and bits 31..K equal the fetch address bits 31..K. Otherwise the lookup reports a miss.
- R4: Returned tag bits K-1..9 have no effect on the hit result.
- R5: A fill accepted while idle writes once (`tag_strobe` high, `tag_rw`=0) at the fill address index. The data is fill address bits 31..K, zeros in bits K-1..9, and 1 in bit 8.
- R6: `tag_strobe` is never high on two consecutive cycles, so every tag RAM cycle begins with a fresh low-to-high edge.
- R7: Invalidate-all writes an all-zero word to every index in ascending order from 0, with one write every two cycles. It keeps `busy` high for 2×entries cycles, and afterwards every lookup misses.
- R8: `hit` is 1 only together with `hit_valid`, so it stays low throughout an invalidate walk.
- R9: Commands given in the same idle cycle are ranked invalidate, then fill, then fetch. The lower-ranked ones are dropped, and so is any command given while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Start a tag lookup |
| fetch_addr | input | 32 | Lookup address |
| fill_req | input | 1 | Write a valid tag for a filled line |
| fill_addr | input | 32 | Address of the filled line |
| inval_req | input | 1 | Clear all tag entries |
| busy | output | 1 | A command is in progress |
| hit_valid | output | 1 | Lookup result is present this cycle |
| hit | output | 1 | Lookup result: stored tag matches |
| tag_strobe | output | 1 | Tag RAM cycle start on rising edge |
| tag_rw | output | 1 | 1 = read, 0 = write |
| tag_index | output | IDX_W | Tag RAM entry index |
| tag_wdata | output | 24 | Tag RAM write data, bus bits 31..8 |
| tag_rdata | input | 24 | Tag RAM read data, bus bits 31..8 |

## Verification
A fetch can coincide with a fill or with an invalidate in the same idle cycle, and a fill can coincide with an invalidate. The bench raises these request pairs on one clock edge. Correct ranking shows in two ways: no `hit_valid` pulse follows the dropped fetch, and the tag RAM cycles carry the winner's index and data. Later lookups then show whether the winning command took effect. A behavioural model kept in the bench predicts `busy`, `hit_valid`, `hit` and every tag RAM cycle, and compares them each clock.

// File: rtl/icache_tag_ctrl.sv
module icache_tag_ctrl #(
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 16,
  localparam int K      = $clog2(CACHE_BYTES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = K - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_req,
  input  logic [31:0]      fetch_addr,
  input  logic             fill_req,
  input  logic [31:0]      fill_addr,
  input  logic             inval_req,
  output logic             busy,
  output logic             hit_valid,
  output logic             hit,
  output logic             tag_strobe,
  output logic             tag_rw,
  output logic [IDX_W-1:0] tag_index,
  output logic [31:8]      tag_wdata,
  input  logic [31:8]      tag_rdata
);

  localparam logic [23:0] TAG_MASK = {24{1'b1}} << (K - 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((1 << IDX_W) - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_INV_HI, S_INV_LO} state_t;

  state_t           state;
  logic             strobe_q, rw_q, hv_q, hit_q;
  logic [IDX_W-1:0] idx_q;
  logic [23:0]      wdata_q, cmp_q;

  wire match = tag_rdata[8] && (((tag_rdata ^ cmp_q) & TAG_MASK) == 24'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      strobe_q <= 1'b0;
      rw_q     <= 1'b1;
      idx_q    <= '0;
      wdata_q  <= '0;
      cmp_q    <= '0;
      hv_q     <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      hv_q     <= 1'b0;
      hit_q    <= 1'b0;
      strobe_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (inval_req) begin
            state    <= S_INV_HI;
            strobe_q <= 1'b1;
            rw_q     <= 1'b0;
            idx_q    <= '0;
            wdata_q  <= '0;
          end else if (fill_req) begin
            state    <= S_WR;
            strobe_q <= 1'b1;
            rw_q     <= 1'b0;
            idx_q    <= fill_addr[K-1:OFF_W];
            wdata_q  <= (fill_addr[31:8] & TAG_MASK) | 24'd1;
          end else if (fetch_req) begin
            state    <= S_RD;
            strobe_q <= 1'b1;
            rw_q     <= 1'b1;
            idx_q    <= fetch_addr[K-1:OFF_W];
            cmp_q    <= fetch_addr[31:8];
          end
        end
        S_RD: begin
          state <= S_IDLE;
          hv_q  <= 1'b1;
          hit_q <= match;
        end
        S_WR: begin
          state <= S_IDLE;
          rw_q  <= 1'b1;
        end
        S_INV_HI: state <= S_INV_LO;
        S_INV_LO: begin
          if (idx_q == LAST_IDX) begin
            state <= S_IDLE;
            rw_q  <= 1'b1;
          end else begin
            state    <= S_INV_HI;
            strobe_q <= 1'b1;
            idx_q    <= idx_q + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign hit_valid  = hv_q;
  assign hit        = hit_q;
  assign tag_strobe = strobe_q;
  assign tag_rw     = rw_q;
  assign tag_index  = idx_q;
  assign tag_wdata  = wdata_q;

endmodule

// File: rtl/icache_tag_ctrl_chk.sv
module icache_tag_ctrl_chk #(
  parameter int CACHE_BYTES = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        hit_valid,
  input logic        hit,
  input logic        tag_strobe,
  input logic        tag_rw,
  input logic [31:8] tag_wdata
);
  localparam int K = $clog2(CACHE_BYTES);
  localparam logic [23:0] KEEP = ({24{1'b1}} << (K - 8)) | 24'd1;

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_strobe |=> !tag_strobe);

  // R8
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_valid);

  // R2
  result_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_strobe && tag_rw) |=> (hit_valid && !busy));

  // R2
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_strobe |-> busy);

  // R5
  unused_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_strobe && !tag_rw) |-> ((tag_wdata & ~KEEP) == 24'd0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $fell(rst_n) |=> (!busy && !tag_strobe && !hit_valid));
endmodule

bind icache_tag_ctrl icache_tag_ctrl_chk #(.CACHE_BYTES(CACHE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .hit_valid(hit_valid), .hit(hit),
  .tag_strobe(tag_strobe), .tag_rw(tag_rw), .tag_wdata(tag_wdata)
);

// File: tb/icache_tag_ctrl_tb.sv
module icache_tag_ctrl_tb;
  localparam int CB = 4096, LB = 16;
  localparam int K = 12, OFF = 4, IW = K - OFF, N = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic fetch_req = 0, fill_req = 0, inval_req = 0;
  logic [31:0] fetch_addr = 0, fill_addr = 0;
  logic busy, hit_valid, hit, tag_strobe, tag_rw;
  logic [IW-1:0] tag_index;
  logic [31:8] tag_wdata, tag_rdata;

  always #2 clk = ~clk;

  icache_tag_ctrl #(.CACHE_BYTES(CB), .LINE_BYTES(LB)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fill_req(fill_req), .fill_addr(fill_addr), .inval_req(inval_req),
    .busy(busy), .hit_valid(hit_valid), .hit(hit), .tag_strobe(tag_strobe),
    .tag_rw(tag_rw), .tag_index(tag_index), .tag_wdata(tag_wdata),
    .tag_rdata(tag_rdata));

  // tag RAM model: cycle acts while strobe is high, data held for the next edge
  logic [31:8] ram [N];
  logic [31:8] ram_q = 0;
  assign tag_rdata = ram_q;
  always @(negedge clk)
    if (tag_strobe) begin
      if (tag_rw) ram_q <= ram[tag_index];
      else ram[tag_index] <= tag_wdata;
    end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  bit ref_v [N];
  int ref_tag [N];
  int cnt = 0;
  bit inv_mode = 0, pend_fetch = 0, pend_hit = 0;
  bit e_hv = 0, e_hit = 0, e_strobe = 0, e_rw = 1;
  int e_idx = 0, e_data = 0;

  always @(posedge clk) begin
    e_hv = 0; e_hit = 0; e_strobe = 0;
    if (!rst_n) begin
      cnt = 0; pend_fetch = 0; inv_mode = 0;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0 && pend_fetch) begin e_hv = 1; e_hit = pend_hit; pend_fetch = 0; end
      if (inv_mode && cnt > 0 && cnt % 2 == 0) begin
        e_strobe = 1; e_idx = N - cnt / 2;
      end
      if (cnt == 0) inv_mode = 0;
    end else if (inval_req) begin
      cnt = 2 * N; inv_mode = 1; e_strobe = 1; e_rw = 0; e_idx = 0; e_data = 0;
      for (int i = 0; i < N; i++) ref_v[i] = 0;
    end else if (fill_req) begin
      int ix;
      ix = (fill_addr >> OFF) % N;
      cnt = 1; e_strobe = 1; e_rw = 0; e_idx = ix;
      e_data = ((fill_addr >> K) << (K - 8)) | 1;
      ref_v[ix] = 1; ref_tag[ix] = fill_addr >> K;
    end else if (fetch_req) begin
      int ix;
      ix = (fetch_addr >> OFF) % N;
      cnt = 1; e_strobe = 1; e_rw = 1; e_idx = ix; pend_fetch = 1;
      pend_hit = ref_v[ix] && (ref_tag[ix] == int'(fetch_addr >> K));
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (cnt > 0), "R9 busy", busy, cnt > 0);
      chk(hit_valid == e_hv, "R2 hit_valid", hit_valid, e_hv);
      chk(hit == e_hit, "R3 hit", hit, e_hit);
      chk(tag_strobe == e_strobe, "R6 strobe", tag_strobe, e_strobe);
      if (inv_mode) chk(!hit, "R8 hit during walk", hit, 0);
      if (tag_strobe && e_strobe) begin
        chk(tag_rw == e_rw, "R2 R5 rw", tag_rw, e_rw);
        chk(int'(tag_index) == e_idx, "R2 R5 R7 index", tag_index, e_idx);
        if (!tag_rw) chk(int'(tag_wdata) == e_data, "R5 R7 wdata", tag_wdata, e_data);
      end
    end
  end

  task automatic cmd(input bit f, input logic [31:0] fa, input bit l,
                     input logic [31:0] la, input bit v);
    @(negedge clk);
    fetch_req = f; fetch_addr = fa; fill_req = l; fill_addr = la; inval_req = v;
    @(negedge clk);
    fetch_req = 0; fill_req = 0; inval_req = 0;
  endtask

  task automatic settle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lookup(input logic [31:0] a, input bit exp, input string req);
    bit seen = 0, got = 0;
    @(negedge clk); fetch_req = 1; fetch_addr = a;
    @(negedge clk); fetch_req = 0;
    @(negedge clk); seen = hit_valid; got = hit;
    chk(seen && got == exp, req, {seen, got}, {1'b1, exp});
    settle();
  endtask

  localparam logic [31:0] A = 32'h0001_2340;
  localparam logic [31:0] B = 32'h0005_6780;
  bit done = 0;

  initial begin
    for (int i = 0; i < N; i++) ram[i] = 24'hABC000;
    ram[8'h34] = {A[31:12], 4'b0000};
    repeat (3) @(negedge clk);
    chk(!busy && !hit_valid && !tag_strobe && !hit, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !hit_valid && !tag_strobe, "R1 after reset", busy, 0);

    lookup(A, 0, "R3 valid bit clear -> miss");
    cmd(0, 0, 1, A, 0); settle();
    chk(ram[8'h34] == {A[31:12], 4'b0001}, "R5 stored word", ram[8'h34], {A[31:12], 4'b0001});
    lookup(A, 1, "R3 hit after fill");
    lookup(A + 32'h0000_000C, 1, "R3 hit other offset");
    lookup(A + 32'h0000_1000, 0, "R3 same index other tag");
    lookup(A + 32'h0000_0010, 0, "R3 neighbour index");
    @(negedge clk); ram[8'h34][11:9] = 3'b101;
    lookup(A, 1, "R4 unused bits ignored");
    lookup(A ^ 32'h8000_0000, 0, "R3 top tag bit differs");

    cmd(1, A, 1, B, 0); settle();
    lookup(B, 1, "R9 fill beats fetch");
    cmd(0, 0, 1, 32'hFFFF_FFF0, 0); settle();
    lookup(32'hFFFF_FFF0, 1, "R3 last index");

    @(negedge clk); fetch_req = 1; fetch_addr = A;
    @(negedge clk); fill_req = 1; fill_addr = 32'h0000_3340; fetch_req = 1;
    @(negedge clk); fill_req = 0; fetch_req = 0;
    settle();
    lookup(32'h0000_3340, 0, "R9 fill while busy dropped");

    cmd(1, A, 1, 32'h0000_3340, 1);
    settle();
    lookup(A, 0, "R7 miss after invalidate");
    lookup(B, 0, "R7 miss after invalidate B");
    lookup(32'h0000_3340, 0, "R9 invalidate beats fill");
    cmd(0, 0, 1, A, 0); settle();
    lookup(A, 1, "R5 refill after invalidate");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule